// File: doc/BRIEF.md
# Time-Ordered Event Scheduler Queue

This block keeps a pool of timed entries and hands them back one at a time once a free-running time input reaches each entry's due time. A scheduled entry either raises an interrupt line (a small line number) or fires an event identifier. The entries sit in a fixed storage pool and are threaded into two singly linked lists. The free list is used last-in first-out. The scheduled list is kept sorted by due time, and entries with the same due time stay in the order they arrived.

A host adds an entry with a delay relative to the current time. It can cancel every pending event that carries a given identifier. At each millisecond boundary it asks for a rebase, which pulls every pending due time back by 1000 ticks and stops at zero. All requests share one channel with a ready signal, because insertion and cancellation walk the list one node per cycle. Fired entries come out on a one-cycle valid/type/payload strobe. A combinational output reports how many cycles may pass before the next entry becomes due, capped by a budget input.

Top module: `sched_queue`

## Requirements
- R1: After reset `req_ready` is 1, `fire_valid` is 0, and `next_cycles` equals `budget`, because the scheduled list is empty.
- R2: An accepted add (`req_op` 0) stores due time `now + req_delay` using the `now` of the accept cycle. The entry later appears on `fire_type`/`fire_payload` with `fire_valid` high. Type encoding: 0 is an interrupt line, 1 is an event.
- R3: Entries fire in non-decreasing due-time order. Entries with equal due times fire in the order they were added.
- R4: While idle, if the head entry's due time is at most `now`, the head is removed and fired, one entry per cycle. The entry is reported on the outputs in the following cycle. Its slot goes back to the free list and can be reused.
- R5: The pool holds DEPTH entries (128 by default). An add that arrives while every slot is in use is discarded, and `drop_full` pulses in the cycle after acceptance.
- R6: An add of type 0 with payload above 15 is discarded. `drop_illegal` pulses in the cycle after acceptance, and nothing is scheduled.
- R7: A cancel (`req_op` 1, identifier on `req_payload`) removes every type-1 entry whose payload matches. Type-0 entries with the same number stay scheduled.
- R8: A rebase (`req_op` 2) sets every scheduled due time d to d-1000 when d > 1000, and to 0 otherwise. The firing order is unchanged.
- R9: `next_cycles` equals `budget` when nothing is scheduled. Otherwise it is the smaller of `budget` and max(head due − `now`, 1).
- R10: `req_ready` is low while a list walk is in progress and in any cycle in which an entry fires. A request is taken only when `req_valid` and `req_ready` are both high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge if valid |
| req_op | input | 2 | 0 add, 1 cancel, 2 rebase |
| req_type | input | 1 | Entry type for add: 0 interrupt line, 1 event |
| req_payload | input | IDW | Line number or event identifier |
| req_delay | input | TW | Ticks from now until due (add) |
| now | input | TW | Current time |
| budget | input | TW | Upper bound for next_cycles |
| fire_valid | output | 1 | One entry fired |
| fire_type | output | 1 | Type of the fired entry |
| fire_payload | output | IDW | Line number or identifier of the fired entry |
| drop_full | output | 1 | Add discarded: pool exhausted |
| drop_illegal | output | 1 | Add discarded: line number out of range |
| next_cycles | output | TW | Cycles until the next due entry, capped by budget |

## Verification
The hardest condition to reach from the ports is a completely exhausted pool, together with the insertion walk's longest path. The stimulus reaches both by adding 128 entries with the same due time, so each add walks to the tail. A 129th add then must be dropped, and the whole batch must drain in arrival order. Rebase saturation at exactly 1000 and 1001 is reached with directed delays at time zero, where zeroed entries fire at once. Random rounds mix adds, cancels and rebases against an ordered list model.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic [1:0] {
        OP_ADD    = 2'd0,
        OP_CANCEL = 2'd1,
        OP_REBASE = 2'd2
    } sched_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_INSERT = 2'd1,
        ST_CANCEL = 2'd2
    } sched_st_e;

    localparam logic KIND_LINE  = 1'b0;
    localparam logic KIND_EVENT = 1'b1;
endpackage

// File: rtl/sched_rebase.sv
module sched_rebase #(
    parameter int TW   = 32,
    parameter int STEP = 1000
) (
    input  logic [TW-1:0] due_i,
    output logic [TW-1:0] due_o
);
    localparam logic [TW-1:0] STEP_V = TW'(STEP);

    always_comb begin
        if (due_i > STEP_V) due_o = due_i - STEP_V;
        else                due_o = '0;
    end
endmodule

// File: rtl/sched_gap.sv
module sched_gap #(
    parameter int TW = 32
) (
    input  logic          live,
    input  logic [TW-1:0] head_due,
    input  logic [TW-1:0] now,
    input  logic [TW-1:0] budget,
    output logic [TW-1:0] gap
);
    logic [TW-1:0] raw;

    always_comb begin
        raw = (head_due > now) ? (head_due - now) : TW'(1);
        if (!live)             gap = budget;
        else if (raw < budget) gap = raw;
        else                   gap = budget;
    end
endmodule

// File: rtl/sched_queue.sv
module sched_queue
    import sched_pkg::*;
#(
    parameter int DEPTH      = 128,
    parameter int TW         = 32,
    parameter int IDW        = 8,
    parameter int IRQ_LIMIT  = 15,
    parameter int REBASE_BY  = 1000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [1:0]     req_op,
    input  logic           req_type,
    input  logic [IDW-1:0] req_payload,
    input  logic [TW-1:0]  req_delay,
    input  logic [TW-1:0]  now,
    input  logic [TW-1:0]  budget,
    output logic           fire_valid,
    output logic           fire_type,
    output logic [IDW-1:0] fire_payload,
    output logic           drop_full,
    output logic           drop_illegal,
    output logic [TW-1:0]  next_cycles
);
    localparam int AW   = $clog2(DEPTH);
    localparam int PTRW = AW + 1;
    localparam logic [PTRW-1:0] NIL = PTRW'(DEPTH);

    typedef struct packed {
        sched_st_e       st;
        logic [PTRW-1:0] head;
        logic [PTRW-1:0] free;
        logic [PTRW-1:0] cur;
        logic [PTRW-1:0] prev;
        logic [PTRW-1:0] ins;
        logic [TW-1:0]   ins_due;
        logic [IDW-1:0]  cid;
        logic            fv;
        logic            fk;
        logic [IDW-1:0]  fp;
        logic            dfull;
        logic            dill;
    } ctl_t;

    ctl_t s_q, s_d;

    logic [TW-1:0]   due_q  [DEPTH];
    logic [TW-1:0]   due_d  [DEPTH];
    logic [TW-1:0]   due_rb [DEPTH];
    logic [PTRW-1:0] nxt_q  [DEPTH];
    logic [PTRW-1:0] nxt_d  [DEPTH];
    logic            kind_q [DEPTH];
    logic            kind_d [DEPTH];
    logic [IDW-1:0]  pay_q  [DEPTH];
    logic [IDW-1:0]  pay_d  [DEPTH];

    // one saturating subtractor per slot: a rebase finishes in one cycle
    for (genvar g = 0; g < DEPTH; g++) begin : g_rb
        sched_rebase #(.TW(TW), .STEP(REBASE_BY)) u_rb (
            .due_i(due_q[g]),
            .due_o(due_rb[g])
        );
    end

    logic [AW-1:0]   head_i, free_i, cur_i, prev_i, ins_i;
    logic [PTRW-1:0] cur_nxt;
    logic [TW-1:0]   head_due, cur_nxt_due, new_due;
    logic            head_live, pop;

    assign head_i      = s_q.head[AW-1:0];
    assign free_i      = s_q.free[AW-1:0];
    assign cur_i       = s_q.cur[AW-1:0];
    assign prev_i      = s_q.prev[AW-1:0];
    assign ins_i       = s_q.ins[AW-1:0];
    assign cur_nxt     = nxt_q[cur_i];
    assign cur_nxt_due = due_q[cur_nxt[AW-1:0]];
    assign head_due    = due_q[head_i];
    assign head_live   = (s_q.head != NIL);
    assign new_due     = now + req_delay;
    assign pop         = (s_q.st == ST_IDLE) && head_live && (head_due <= now);
    assign req_ready   = (s_q.st == ST_IDLE) && !pop;

    sched_gap #(.TW(TW)) u_gap (
        .live    (head_live),
        .head_due(head_due),
        .now     (now),
        .budget  (budget),
        .gap     (next_cycles)
    );

    always_comb begin
        s_d      = s_q;
        due_d    = due_q;
        nxt_d    = nxt_q;
        kind_d   = kind_q;
        pay_d    = pay_q;
        s_d.fv    = 1'b0;
        s_d.dfull = 1'b0;
        s_d.dill  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (pop) begin
                    s_d.fv       = 1'b1;
                    s_d.fk       = kind_q[head_i];
                    s_d.fp       = pay_q[head_i];
                    s_d.head     = nxt_q[head_i];
                    nxt_d[head_i] = s_q.free;
                    s_d.free     = s_q.head;
                end else if (req_valid) begin
                    unique case (sched_op_e'(req_op))
                        OP_ADD: begin
                            if (req_type == KIND_LINE && req_payload > IDW'(IRQ_LIMIT)) begin
                                s_d.dill = 1'b1;
                            end else if (s_q.free == NIL) begin
                                s_d.dfull = 1'b1;
                            end else begin
                                s_d.free       = nxt_q[free_i];
                                due_d[free_i]  = new_due;
                                kind_d[free_i] = req_type;
                                pay_d[free_i]  = req_payload;
                                s_d.ins        = s_q.free;
                                s_d.ins_due    = new_due;
                                if (!head_live || head_due > new_due) begin
                                    nxt_d[free_i] = s_q.head;
                                    s_d.head      = s_q.free;
                                end else begin
                                    s_d.cur = s_q.head;
                                    s_d.st  = ST_INSERT;
                                end
                            end
                        end
                        OP_CANCEL: begin
                            s_d.cid  = req_payload;
                            s_d.cur  = s_q.head;
                            s_d.prev = NIL;
                            s_d.st   = ST_CANCEL;
                        end
                        OP_REBASE: begin
                            for (int i = 0; i < DEPTH; i++) due_d[i] = due_rb[i];
                        end
                        default: ;
                    endcase
                end
            end
            ST_INSERT: begin
                if (cur_nxt == NIL || cur_nxt_due > s_q.ins_due) begin
                    nxt_d[ins_i] = cur_nxt;
                    nxt_d[cur_i] = s_q.ins;
                    s_d.st       = ST_IDLE;
                end else begin
                    s_d.cur = cur_nxt;
                end
            end
            ST_CANCEL: begin
                if (s_q.cur == NIL) begin
                    s_d.st = ST_IDLE;
                end else begin
                    if (kind_q[cur_i] == KIND_EVENT && pay_q[cur_i] == s_q.cid) begin
                        if (s_q.prev == NIL) s_d.head = cur_nxt;
                        else                 nxt_d[prev_i] = cur_nxt;
                        nxt_d[cur_i] = s_q.free;
                        s_d.free     = s_q.cur;
                    end else begin
                        s_d.prev = s_q.cur;
                    end
                    s_d.cur = cur_nxt;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.head <= NIL;
            s_q.free <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                nxt_q[i]  <= (i == DEPTH - 1) ? NIL : PTRW'(i + 1);
                due_q[i]  <= '0;
                kind_q[i] <= 1'b0;
                pay_q[i]  <= '0;
            end
        end else begin
            s_q    <= s_d;
            due_q  <= due_d;
            nxt_q  <= nxt_d;
            kind_q <= kind_d;
            pay_q  <= pay_d;
        end
    end

    assign fire_valid   = s_q.fv;
    assign fire_type    = s_q.fk;
    assign fire_payload = s_q.fp;
    assign drop_full    = s_q.dfull;
    assign drop_illegal = s_q.dill;
endmodule

// File: rtl/sched_queue_chk.sv
module sched_queue_chk #(
    parameter int TW        = 32,
    parameter int IDW       = 8,
    parameter int IRQ_LIMIT = 15
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic [1:0]     req_op,
    input logic           req_type,
    input logic [IDW-1:0] req_payload,
    input logic [TW-1:0]  budget,
    input logic           fire_valid,
    input logic           fire_type,
    input logic [IDW-1:0] fire_payload,
    input logic           drop_full,
    input logic           drop_illegal,
    input logic [TW-1:0]  next_cycles
);
    a_r10_fire_holds_ready: assert property (@(posedge clk) disable iff (!rst_n)
        fire_valid |-> $past(!req_ready));

    a_r10_cancel_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'd1) |=> !req_ready);

    a_r6_illegal_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'd0 && !req_type &&
         req_payload > IDW'(IRQ_LIMIT)) |=> drop_illegal);

    a_r6_line_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_valid && !fire_type) |-> (fire_payload <= IDW'(IRQ_LIMIT)));

    a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fire_valid, drop_full, drop_illegal}));

    a_r9_within_budget: assert property (@(posedge clk) disable iff (!rst_n)
        next_cycles <= budget);

    a_r9_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (budget != '0) |-> (next_cycles != '0));
endmodule

bind sched_queue sched_queue_chk #(.TW(TW), .IDW(IDW), .IRQ_LIMIT(IRQ_LIMIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_type(req_type), .req_payload(req_payload),
    .budget(budget), .fire_valid(fire_valid), .fire_type(fire_type),
    .fire_payload(fire_payload), .drop_full(drop_full),
    .drop_illegal(drop_illegal), .next_cycles(next_cycles)
);

// File: tb/sim_sched_queue.sv
`timescale 1ns/1ps
module sim_sched_queue;
    localparam int TW = 32;
    localparam int IDW = 8;
    localparam int DEPTH = 128;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [1:0]     req_op = 2'd0;
    logic           req_type = 1'b0;
    logic [IDW-1:0] req_payload = '0;
    logic [TW-1:0]  req_delay = '0;
    logic [TW-1:0]  now = '0;
    logic [TW-1:0]  budget = 32'd500;
    logic           fire_valid, fire_type, drop_full, drop_illegal;
    logic [IDW-1:0] fire_payload;
    logic [TW-1:0]  next_cycles;

    always #2.5 clk = ~clk;

    sched_queue u0 (.*);

    int n_chk = 0;
    int n_fail = 0;

    // reference list model
    longint m_due  [0:255];
    int     m_kind [0:255];
    int     m_pay  [0:255];
    int     m_n = 0;

    // fire log
    int l_kind [0:4095];
    int l_pay  [0:4095];
    int l_n = 0;
    int l_rd = 0;

    always @(negedge clk) begin
        if (rst_n && fire_valid) begin
            l_kind[l_n] = int'(fire_type);
            l_pay[l_n]  = int'(fire_payload);
            l_n = l_n + 1;
        end
    end

    task automatic expect_eq(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic m_add(input int kind, input int pay, input longint due);
        int pos;
        if (kind == 0 && pay > 15) return;
        if (m_n == DEPTH) return;
        pos = m_n;
        for (int i = 0; i < m_n; i++) begin
            if (m_due[i] > due) begin pos = i; break; end
        end
        for (int i = m_n; i > pos; i--) begin
            m_due[i] = m_due[i-1]; m_kind[i] = m_kind[i-1]; m_pay[i] = m_pay[i-1];
        end
        m_due[pos] = due; m_kind[pos] = kind; m_pay[pos] = pay;
        m_n++;
    endtask

    task automatic m_cancel(input int id);
        int k = 0;
        for (int i = 0; i < m_n; i++) begin
            if (!(m_kind[i] == 1 && m_pay[i] == id)) begin
                m_due[k] = m_due[i]; m_kind[k] = m_kind[i]; m_pay[k] = m_pay[i];
                k++;
            end
        end
        m_n = k;
    endtask

    task automatic m_rebase();
        for (int i = 0; i < m_n; i++)
            m_due[i] = (m_due[i] > 1000) ? m_due[i] - 1000 : 0;
    endtask

    function automatic longint m_gap(input longint t, input longint b);
        longint g;
        if (m_n == 0) return b;
        g = (m_due[0] > t) ? m_due[0] - t : 1;
        return (g < b) ? g : b;
    endfunction

    task automatic wait_idle();
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
    endtask

    // drives one request; returns drop flags and ready one cycle after acceptance
    task automatic send(input int op, input int kind, input int pay, input int dly,
                        output bit dfull, output bit dill, output bit rdy_after);
        @(negedge clk);
        req_op = 2'(op); req_type = kind[0]; req_payload = IDW'(pay);
        req_delay = TW'(dly); req_valid = 1'b1;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
        dfull = drop_full; dill = drop_illegal; rdy_after = req_ready;
    endtask

    task automatic drain(input string tag, input longint t);
        int exp_cnt = 0;
        @(negedge clk);
        now = TW'(t);
        repeat (m_n + 6) @(negedge clk);
        while (exp_cnt < m_n && m_due[exp_cnt] <= t) exp_cnt++;
        expect_eq({tag, " fire count"}, l_n - l_rd, exp_cnt);
        for (int i = 0; i < exp_cnt; i++) begin
            if (l_rd + i < l_n) begin
                expect_eq({tag, " fire type"}, l_kind[l_rd+i], m_kind[i]);
                expect_eq({tag, " fire payload"}, l_pay[l_rd+i], m_pay[i]);
            end
        end
        l_rd = l_n;
        for (int i = exp_cnt; i < m_n; i++) begin
            m_due[i-exp_cnt] = m_due[i]; m_kind[i-exp_cnt] = m_kind[i]; m_pay[i-exp_cnt] = m_pay[i];
        end
        m_n = m_n - exp_cnt;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        bit df, di, ra;
        void'($urandom(32'd20240917));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        expect_eq("R1 ready", req_ready, 1);
        expect_eq("R1 fire_valid", fire_valid, 0);
        expect_eq("R1 next_cycles", next_cycles, 500);

        // R6: out-of-range line number rejected
        send(0, 0, 20, 5, df, di, ra);
        expect_eq("R6 drop_illegal", di, 1);
        expect_eq("R6 nothing scheduled", next_cycles, 500);

        // R2 R3 R7 R9 R10 directed
        @(negedge clk); now = 100;
        send(0, 1, 5, 50, df, di, ra); m_add(1, 5, 150);
        send(0, 0, 3, 20, df, di, ra); m_add(0, 3, 120);
        send(0, 1, 7, 50, df, di, ra); m_add(1, 7, 150);
        expect_eq("R10 busy during walk", ra, 0);
        send(0, 1, 3, 30, df, di, ra); m_add(1, 3, 130);
        wait_idle();
        expect_eq("R9 gap", next_cycles, 20);
        budget = 10; #1;
        expect_eq("R9 budget cap", next_cycles, 10);
        budget = 500;
        send(1, 0, 3, 0, df, di, ra); m_cancel(3);
        expect_eq("R10 busy during cancel", ra, 0);
        wait_idle();
        drain("R3 R7 directed", 200);

        // R8 rebase with saturation boundaries
        @(negedge clk); now = 0; budget = 100000;
        send(0, 1, 1, 2500, df, di, ra); m_add(1, 1, 2500);
        send(0, 1, 2, 700,  df, di, ra); m_add(1, 2, 700);
        send(0, 1, 4, 1000, df, di, ra); m_add(1, 4, 1000);
        send(0, 1, 9, 1001, df, di, ra); m_add(1, 9, 1001);
        wait_idle();
        expect_eq("R9 gap before rebase", next_cycles, 700);
        send(2, 0, 0, 0, df, di, ra); m_rebase();
        drain("R8 zeroed fire", 0);
        wait_idle();
        expect_eq("R8 gap after rebase", next_cycles, 1);
        drain("R8 1001 to 1", 1);
        expect_eq("R8 head rebased", next_cycles, 1499);
        drain("R4 not yet due", 1499);
        drain("R4 due inclusive", 1500);

        // R5 full pool, longest insertion walks
        @(negedge clk); now = 0;
        for (int i = 0; i < DEPTH; i++) begin
            send(0, 1, i, 10, df, di, ra); m_add(1, i, 10);
        end
        send(0, 1, 200, 10, df, di, ra);
        expect_eq("R5 drop_full", df, 1);
        drain("R5 R3 equal-due order", 10);
        send(0, 0, 2, 5, df, di, ra); m_add(0, 2, 15);
        expect_eq("R4 slot reuse no drop", df, 0);
        drain("R4 reuse fire", 15);

        // random rounds
        for (int r = 0; r < 40; r++) begin
            longint base = $urandom % 2000;
            int k = 1 + $urandom % 20;
            @(negedge clk); now = TW'(base); budget = TW'(1 + $urandom % 600);
            for (int j = 0; j < k; j++) begin
                if ($urandom % 100 < 15) begin
                    int id = $urandom % 8;
                    send(1, 0, id, 0, df, di, ra); m_cancel(id);
                end else begin
                    int kd = $urandom % 2;
                    int py = kd ? $urandom % 8 : $urandom % 18;
                    int dl = 1 + $urandom % 300;
                    send(0, kd, py, dl, df, di, ra);
                    expect_eq("R6 random drop_illegal", di, (kd == 0 && py > 15) ? 1 : 0);
                    m_add(kd, py, base + dl);
                end
            end
            wait_idle();
            expect_eq("R9 random gap", next_cycles, m_gap(base, budget));
            if ($urandom % 100 < 30) begin
                send(2, 0, 0, 0, df, di, ra); m_rebase();
            end
            drain("R2 R3 random", base + 400);
        end
        summary();
    end
endmodule